// File: doc/BRIEF.md
# Serial Configuration Shift Register with Strobe Latch

This block takes a configuration word one bit at a time on a serial data line. Each rising edge of the serial clock moves the contents of an internal shift chain up one stage and puts the new bit into stage 0. The chain can be any length. The default of 39 stages holds a 32-bit payload plus 7 protection bits.

A separate strobe line copies the whole chain into a parallel output register. The parallel outputs change only when the strobe is pulsed, so a new word can be shifted in while the old one still drives the downstream logic.

Two serial readback outputs come out of the chain:

- One is taken from the last stage.
- The other is taken a fixed number of stages earlier, which is 7 by default. A system that sends words without protection bits uses this tap, so its echoed data lines up with its shorter frame.

An active-low reset clears both the chain and the parallel register at once, without waiting for a clock.

Top module: `ser_cfg_shifter`

## Requirements
- R1: The chain length is the parameter `N` (default 39). `par_q` is `N` bits wide, and bit i of `par_q` comes from chain stage i.
- R2: On each rising edge of `sclk` with `rst_n` high, chain stage 0 takes `sdin` and every stage i>0 takes the old value of stage i-1.
- R3: `sdo_end` shows chain stage `N-1`. A bit clocked in at some `sclk` edge appears on `sdo_end` right after the `N`-th rising edge, counting that edge as the first.
- R4: `sdo_short` shows chain stage `N-1-CHK`, where the parameter `CHK` defaults to 7. A bit appears there right after its `(N-CHK)`-th rising edge. `sdo_end` always repeats the value `sdo_short` had `CHK` edges earlier.
- R5: On a rising edge of `strobe` with `rst_n` high, `par_q` takes the full content of the chain.
- R6: Between strobe edges, `par_q` holds its value however many `sclk` edges occur.
- R7: While `rst_n` is low, the chain and `par_q` are zero, so `sdo_end`, `sdo_short` and `par_q` read zero. This holds immediately and needs no clock edge.
- R8: Edges on `sclk` or `strobe` while `rst_n` is low have no effect. All outputs stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock; shifts on its rising edge |
| sdin | input | 1 | Serial data, sampled on the rising edge of `sclk` |
| strobe | input | 1 | Rising edge copies the chain into `par_q` |
| sdo_end | output | 1 | Readback from the last chain stage |
| sdo_short | output | 1 | Readback from `CHK` stages before the end |
| par_q | output | N | Latched parallel configuration word |

## Verification
A shifted bit shows up on `sdo_short` after `N-CHK` rising `sclk` edges and on `sdo_end` after `N` edges, counting the edge that captured it as the first. A strobe updates `par_q` on the same edge, and a falling reset clears everything with no edge at all. The bench drives each clock by hand, one edge at a time. It samples half a period after each edge, with the next edge not yet issued, so every expected value matches exactly one edge count. A walking-one pass counts the edges explicitly. The pattern sweep checks all outputs after every single shift and after every strobe.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;

  // Chain index of the shortened readback tap.
  function automatic int unsigned short_tap_idx(input int unsigned n, input int unsigned chk);
    if (chk >= n) return 0;
    return n - 1 - chk;
  endfunction

  // Chain index of the full-length readback tap.
  function automatic int unsigned end_tap_idx(input int unsigned n);
    return n - 1;
  endfunction

  // Number of sclk edges before a freshly captured bit reaches a stage.
  function automatic int unsigned edges_to_stage(input int unsigned stage);
    return stage + 1;
  endfunction

endpackage

// File: rtl/scs_shift_chain.sv
module scs_shift_chain #(
  parameter int unsigned N = 39
) (
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdin,
  output logic [N-1:0] chain_q
);

  // Each stage is its own flop; stage 0 is fed from the line.
  for (genvar s = 0; s < N; s++) begin : g_stage
    logic d_in;
    if (s == 0) begin : g_head
      assign d_in = sdin;
    end else begin : g_body
      assign d_in = chain_q[s-1];
    end

    always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= 1'b0;
      else        chain_q[s] <= d_in;
    end
  end

endmodule

// File: rtl/scs_strobe_latch.sv
module scs_strobe_latch #(
  parameter int unsigned N = 39
) (
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [N-1:0] chain_q,
  output logic [N-1:0] par_q,
  output logic         load_tog
);

  always_ff @(posedge strobe or negedge rst_n) begin
    if (!rst_n) begin
      par_q    <= '0;
      load_tog <= 1'b0;
    end else begin
      par_q    <= chain_q;
      load_tog <= ~load_tog;
    end
  end

endmodule

// File: rtl/scs_tap_sel.sv
module scs_tap_sel
  import ser_cfg_pkg::*;
#(
  parameter int unsigned N   = 39,
  parameter int unsigned CHK = 7
) (
  input  logic [N-1:0] chain_q,
  output logic         tap_end,
  output logic         tap_short
);

  localparam int unsigned END_IDX   = end_tap_idx(N);
  localparam int unsigned SHORT_IDX = short_tap_idx(N, CHK);

  assign tap_end = chain_q[END_IDX];

  if (CHK == 0) begin : g_same
    assign tap_short = tap_end;
  end else begin : g_early
    assign tap_short = chain_q[SHORT_IDX];
  end

endmodule

// File: rtl/ser_cfg_shifter.sv
module ser_cfg_shifter #(
  parameter int unsigned N   = 39,
  parameter int unsigned CHK = 7
) (
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdin,
  input  logic         strobe,
  output logic         sdo_end,
  output logic         sdo_short,
  output logic [N-1:0] par_q
);

  // Named internal events, observed by the bound checker.
  logic [N-1:0] chain_q;
  logic         load_tog;

  scs_shift_chain #(.N(N)) u_chain (
    .rst_n   (rst_n),
    .sclk    (sclk),
    .sdin    (sdin),
    .chain_q (chain_q)
  );

  scs_strobe_latch #(.N(N)) u_latch (
    .rst_n    (rst_n),
    .strobe   (strobe),
    .chain_q  (chain_q),
    .par_q    (par_q),
    .load_tog (load_tog)
  );

  scs_tap_sel #(.N(N), .CHK(CHK)) u_taps (
    .chain_q   (chain_q),
    .tap_end   (sdo_end),
    .tap_short (sdo_short)
  );

endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
  parameter int unsigned N   = 39,
  parameter int unsigned CHK = 7
) (
  input logic         rst_n,
  input logic         sclk,
  input logic         sdin,
  input logic         sdo_end,
  input logic         sdo_short,
  input logic [N-1:0] par_q,
  input logic [N-1:0] chain_q,
  input logic         load_tog
);

  localparam int unsigned CW = $clog2(CHK + 2) + 1;

  // Counts the sclk edges since reset, saturating, so the tap relation
  // never looks back past a reset.
  logic [CW-1:0] edge_cnt;
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) edge_cnt <= '0;
    else if (edge_cnt <= CW'(CHK)) edge_cnt <= edge_cnt + 1'b1;
  end

  // R2: the head stage captures the line
  assert_head_capture_R2: assert property (@(posedge sclk) disable iff (!rst_n)
    rst_n |=> chain_q[0] == $past(sdin));

  // R2: the body stages move up by one
  assert_body_shift_R2: assert property (@(posedge sclk) disable iff (!rst_n)
    rst_n |=> chain_q[N-1:1] == $past(chain_q[N-2:0]));

  // R4: the end tap repeats the short tap CHK edges later
  assert_tap_delay_R4: assert property (@(posedge sclk) disable iff (!rst_n)
    (edge_cnt > CW'(CHK)) |-> sdo_end == $past(sdo_short, CHK));

  // R6: with no strobe edge in between, the parallel word does not move
  assert_par_hold_R6: assert property (@(posedge sclk) disable iff (!rst_n)
    $stable(load_tog) |-> $stable(par_q));

  // R7 / R8: everything reads zero while reset is held
  assert_reset_clear_R7: assert property (@(posedge sclk)
    !rst_n |-> (par_q == '0 && sdo_end == 1'b0 && sdo_short == 1'b0));

endmodule

bind ser_cfg_shifter scs_checker #(.N(N), .CHK(CHK)) u_chk (
  .rst_n     (rst_n),
  .sclk      (sclk),
  .sdin      (sdin),
  .sdo_end   (sdo_end),
  .sdo_short (sdo_short),
  .par_q     (par_q),
  .chain_q   (chain_q),
  .load_tog  (load_tog)
);

// File: tb/sim_ser_cfg_shifter.sv
module sim_ser_cfg_shifter;

  localparam int unsigned N      = 12;
  localparam int unsigned CHK    = 7;
  localparam int          PERIOD = 10;
  localparam logic [N-1:0] MASK  = {N{1'b1}};

  logic         rst_n, sclk, sdin, strobe;
  logic         sdo_end, sdo_short;
  logic [N-1:0] par_q;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] mdl;   // expected chain
  logic [N-1:0] held;  // expected parallel word

  ser_cfg_shifter #(.N(N), .CHK(CHK)) u0 (
    .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .strobe(strobe),
    .sdo_end(sdo_end), .sdo_short(sdo_short), .par_q(par_q)
  );

  task automatic check(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_taps(input string req);
    check(req, "sdo_end",   N'(sdo_end),   (mdl >> (N-1)) & 1);
    check(req, "sdo_short", N'(sdo_short), (mdl >> (N-1-CHK)) & 1);
  endtask

  task automatic shift_bit(input logic b);
    sdin = b;
    #(PERIOD/2) sclk = 1'b1;
    if (rst_n) mdl = ((mdl << 1) | N'(b)) & MASK;
    #(PERIOD/2) sclk = 1'b0;
  endtask

  task automatic pulse_strobe();
    #(PERIOD/2) strobe = 1'b1;
    if (rst_n) held = mdl;
    #(PERIOD/2) strobe = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b1; sclk = 1'b0; sdin = 1'b0; strobe = 1'b0;
    mdl = '0; held = '0;
    #2 rst_n = 1'b0;
    #3;
    // R7: reset state
    check("R7", "par_q at reset", par_q, '0);
    check_taps("R7");

    // R8: edges under reset are ignored
    shift_bit(1'b1); shift_bit(1'b1);
    pulse_strobe();
    check("R8", "par_q after edges in reset", par_q, '0);
    check_taps("R8");
    #(PERIOD) rst_n = 1'b1;
    #(PERIOD);

    // R3/R4: walking one, counted edge by edge
    shift_bit(1'b1);
    for (int j = 2; j <= N + 2; j++) begin
      shift_bit(1'b0);
      check("R3", "sdo_end edge count",   N'(sdo_end),   N'(j == N));
      check("R4", "sdo_short edge count", N'(sdo_short), N'(j == N - CHK));
    end

    // R1/R2/R5/R6: sweep of word patterns, MSB first
    for (int w = 0; w < 256; w++) begin
      logic [N-1:0] v;
      v = N'((w * 37 + (w << 4) + 5) ^ (w >> 3));
      for (int k = N - 1; k >= 0; k--) begin
        shift_bit(v[k]);
        check_taps("R2");
        check("R6", "par_q hold while shifting", par_q, held);
      end
      pulse_strobe();
      check("R5", "par_q after strobe", par_q, held);
      check("R1", "par_q full width word", par_q, v);
    end

    // R7: asynchronous clear in the middle of a run
    for (int k = 0; k < N; k++) shift_bit(1'b1);
    pulse_strobe();
    check("R5", "par_q all ones", par_q, MASK);
    #(PERIOD/4) rst_n = 1'b0;
    mdl = '0; held = '0;
    #1;
    check("R7", "par_q async clear", par_q, '0);
    check_taps("R7");
    #(PERIOD) rst_n = 1'b1;
    #(PERIOD);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule